// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers 32 external event lines and turns them into two interrupt request outputs and one wake output. For each line, software chooses a trigger: rising edge, falling edge, both edges, high level or low level. A line can also be left inactive. Each line then passes through an input-select bit and a mask bit. Its route bit then sends it to one of the two request outputs.

Every raw line is first passed through a two-stage synchroniser. The block then compares the synchronised value with its value in the previous cycle to find edges. Detected edges are stored in two separate sticky registers, one for rising edges and one for falling edges. Software clears these by writing ones. Level triggers use the live synchronised value and are never stored.

Every control register has three word addresses: a read address, a set address and a clear address. A written 1 changes a bit and a written 0 leaves it unchanged. Two read-only words show which sources are pending on each request output.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the three trigger-code registers, the mask register, the wake register, both edge registers and the test bit all read 0. The input-select and route registers read all ones. req0_o, req1_o and wake_o are 0.
- R2: Control register k has three word addresses. It is read at 4k, set by writing ones at 4k+1 and cleared by writing ones at 4k+2. The order of k is: trigger bit 0 (k=0), trigger bit 1 (k=1), trigger bit 2 (k=2), input select (k=3), route (k=4), wake (k=5), mask (k=6). Bit i of every register belongs to source i. Data bits written as 0 leave the register unchanged.
- R3: Trigger code 001 (bit2:bit1:bit0) captures rising edges into the rising-edge register. That register is read at address 28, and writing ones at address 29 clears it. A captured bit stays pending after the input falls again.
- R4: Trigger code 010 captures falling edges into the falling-edge register. That register is read at address 30, and writing ones at address 31 clears it.
- R5: Trigger code 011 makes a source pending from either of its captured edges.
- R6: Trigger code 101 makes a source active while its synchronised input is high. Code 110 makes it active while the input is low. Neither level is stored.
- R7: Codes 000, 100 and 111 never make a source active and never capture edges.
- R8: A source is pending only when its mask bit is 1 and its condition is active.
- R9: A pending source with route bit 1 shows in the word at address 32 and drives req0_o. A pending source with route bit 0 shows in the word at address 33 and drives req1_o. Each request output is the registered OR of its word.
- R10: A source whose input-select bit is 0 is never active and captures no edge.
- R11: wake_o is the registered OR, over all sources, of (wake bit AND active condition). The mask bit does not affect it.
- R12: If a qualifying edge and a write of 1 to the matching clear bit reach the same clock edge, the captured bit ends up 1.
- R13: Suppose an input changes just before clock edge k. In an edge trigger, the status word shows it after edge k+2 and the request output after edge k+3. In a level trigger, the status word shows it after edge k+1 and the request output after edge k+2.
- R14: Bit 0 of address 34 is a test bit. It can be written and read back, and it has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw event lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | NUM_SRC | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | NUM_SRC | Read data, combinational from rd_addr |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake output |

## Verification
Edge capture and the software clear of a captured bit can land on the same clock edge. The bench sets this up on purpose. First it captures a rising edge on one source. Then it lets the input fall and times a second rise so that its synchronised edge meets a clear write aimed at the same bit. The captured bit must read back as 1, with the request still asserted. A plain clear with no edge follows and must bring the bit to 0. Randomised rounds then mix clear writes with fresh input patterns, and a bench model predicts the captured state.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_SRC = 32;
  localparam int ADDR_W  = 6;
  localparam int NUM_CTL = 7;

  // control register indices; addresses are derived from them
  localparam int IDX_TRIG0  = 0;
  localparam int IDX_TRIG1  = 1;
  localparam int IDX_TRIG2  = 2;
  localparam int IDX_SRCSEL = 3;
  localparam int IDX_ROUTE  = 4;
  localparam int IDX_WAKE   = 5;
  localparam int IDX_MASK   = 6;

  // access kinds within a control register's address group
  localparam int K_RD  = 0;
  localparam int K_SET = 1;
  localparam int K_CLR = 2;

  localparam logic [ADDR_W-1:0] A_RISE_RD  = 6'd28;
  localparam logic [ADDR_W-1:0] A_RISE_CLR = 6'd29;
  localparam logic [ADDR_W-1:0] A_FALL_RD  = 6'd30;
  localparam logic [ADDR_W-1:0] A_FALL_CLR = 6'd31;
  localparam logic [ADDR_W-1:0] A_PEND0    = 6'd32;
  localparam logic [ADDR_W-1:0] A_PEND1    = 6'd33;
  localparam logic [ADDR_W-1:0] A_TEST     = 6'd34;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;

  function automatic logic [ADDR_W-1:0] ctl_addr(input int idx, input int kind);
    return ADDR_W'(idx * 4 + kind);
  endfunction
endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = raw_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [N-1:0]              wr_data,
  output logic [NUM_CTL-1:0][N-1:0] ctl_o,
  output logic                      test_o
);
  logic [NUM_CTL-1:0][N-1:0] ctl_q, ctl_d;
  logic [NUM_CTL-1:0]        set_hit, clr_hit, ctl_en;

  for (genvar r = 0; r < NUM_CTL; r++) begin : g_ctl
    localparam logic [N-1:0] RST_VAL =
      ((r == IDX_SRCSEL) || (r == IDX_ROUTE)) ? {N{1'b1}} : {N{1'b0}};

    assign set_hit[r] = wr_en && (wr_addr == AW'(ctl_addr(r, K_SET)));
    assign clr_hit[r] = wr_en && (wr_addr == AW'(ctl_addr(r, K_CLR)));
    assign ctl_en[r]  = set_hit[r] | clr_hit[r];
    assign ctl_d[r]   = set_hit[r] ? (ctl_q[r] | wr_data) : (ctl_q[r] & ~wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q[r] <= RST_VAL;
      else if (ctl_en[r])  ctl_q[r] <= ctl_d[r];
    end
  end

  logic test_q, test_d, test_en;
  assign test_en = wr_en && (wr_addr == AW'(A_TEST));
  assign test_d  = wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= 1'b0;
    else if (test_en) test_q <= test_d;
  end

  assign ctl_o  = ctl_q;
  assign test_o = test_q;
endmodule

// File: rtl/evt_irq_detect.sv
module evt_irq_detect
  import evt_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] trig0_i,
  input  logic [N-1:0] trig1_i,
  input  logic [N-1:0] trig2_i,
  input  logic [N-1:0] srcsel_i,
  input  logic [N-1:0] rise_clr_i,
  input  logic [N-1:0] fall_clr_i,
  output logic [N-1:0] cond_o,
  output logic [N-1:0] rise_hit_o,
  output logic [N-1:0] rise_lat_o,
  output logic [N-1:0] fall_lat_o
);
  logic [N-1:0] rise_q, fall_q, rise_d, fall_d;
  logic [N-1:0] rise_en, fall_en, hi_en, lo_en, fall_hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] code;
    assign code       = {trig2_i[i], trig1_i[i], trig0_i[i]};
    assign rise_en[i] = (code == TRIG_RISE) || (code == TRIG_BOTH);
    assign fall_en[i] = (code == TRIG_FALL) || (code == TRIG_BOTH);
    assign hi_en[i]   = (code == TRIG_HIGH);
    assign lo_en[i]   = (code == TRIG_LOW);
  end

  always_comb begin
    rise_hit_o = lvl_i & ~prev_i & srcsel_i & rise_en;
    fall_hit   = ~lvl_i & prev_i & srcsel_i & fall_en;
    // a new edge outranks a clear landing in the same cycle
    rise_d     = rise_hit_o | (rise_q & ~rise_clr_i);
    fall_d     = fall_hit   | (fall_q & ~fall_clr_i);
    cond_o     = srcsel_i & ((rise_q & rise_en) | (fall_q & fall_en) |
                             (lvl_i & hi_en) | (~lvl_i & lo_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise_lat_o = rise_q;
  assign fall_lat_o = fall_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC_P = NUM_SRC,
  parameter int ADDR_W_P  = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC_P-1:0] src_in,
  input  logic                 wr_en,
  input  logic [ADDR_W_P-1:0]  wr_addr,
  input  logic [NUM_SRC_P-1:0] wr_data,
  input  logic [ADDR_W_P-1:0]  rd_addr,
  output logic [NUM_SRC_P-1:0] rd_data,
  output logic                 req0_o,
  output logic                 req1_o,
  output logic                 wake_o
);
  localparam int N  = NUM_SRC_P;
  localparam int AW = ADDR_W_P;

  logic [N-1:0] lvl, prev;
  logic [NUM_CTL-1:0][N-1:0] ctl_q;
  logic         test_q;
  logic [N-1:0] mask_q, wake_q, route_q;
  logic [N-1:0] rise_clr, fall_clr;
  logic [N-1:0] cond, rise_hit, rise_lat, fall_lat;
  logic [N-1:0] pend, pend0, pend1;

  evt_irq_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(src_in), .lvl_o(lvl), .prev_o(prev)
  );

  evt_irq_regs #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl_o(ctl_q), .test_o(test_q)
  );

  assign mask_q   = ctl_q[IDX_MASK];
  assign wake_q   = ctl_q[IDX_WAKE];
  assign route_q  = ctl_q[IDX_ROUTE];
  assign rise_clr = (wr_en && (wr_addr == AW'(A_RISE_CLR))) ? wr_data : '0;
  assign fall_clr = (wr_en && (wr_addr == AW'(A_FALL_CLR))) ? wr_data : '0;

  evt_irq_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .prev_i(prev),
    .trig0_i(ctl_q[IDX_TRIG0]), .trig1_i(ctl_q[IDX_TRIG1]),
    .trig2_i(ctl_q[IDX_TRIG2]), .srcsel_i(ctl_q[IDX_SRCSEL]),
    .rise_clr_i(rise_clr), .fall_clr_i(fall_clr),
    .cond_o(cond), .rise_hit_o(rise_hit),
    .rise_lat_o(rise_lat), .fall_lat_o(fall_lat)
  );

  always_comb begin
    pend  = cond & mask_q;
    pend0 = pend & route_q;
    pend1 = pend & ~route_q;
  end

  logic req0_q, req1_q, wake_q_o;
  logic req0_d, req1_d, wake_d;

  always_comb begin
    req0_d = |pend0;
    req1_d = |pend1;
    wake_d = |(cond & wake_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req0_q   <= 1'b0;
      req1_q   <= 1'b0;
      wake_q_o <= 1'b0;
    end else begin
      req0_q   <= req0_d;
      req1_q   <= req1_d;
      wake_q_o <= wake_d;
    end
  end

  assign req0_o = req0_q;
  assign req1_o = req1_q;
  assign wake_o = wake_q_o;

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_CTL; r++) begin
      if (rd_addr == AW'(ctl_addr(r, K_RD))) rd_data = ctl_q[r];
    end
    if (rd_addr == AW'(A_RISE_RD)) rd_data = rise_lat;
    if (rd_addr == AW'(A_FALL_RD)) rd_data = fall_lat;
    if (rd_addr == AW'(A_PEND0))   rd_data = pend0;
    if (rd_addr == AW'(A_PEND1))   rd_data = pend1;
    if (rd_addr == AW'(A_TEST))    rd_data = {{(N-1){1'b0}}, test_q};
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [N-1:0] wr_data,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] wake_q,
  input logic [N-1:0] rise_hit,
  input logic [N-1:0] rise_lat,
  input logic         req0_o,
  input logic         req1_o,
  input logic         wake_o
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ($past(mask_q) == '0)) |-> (!req0_o && !req1_o));

  // R11
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ($past(wake_q) == '0)) |-> !wake_o);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ctl_addr(IDX_MASK, K_SET)))
      |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ctl_addr(IDX_MASK, K_CLR)))
      |=> ((mask_q & $past(wr_data)) == '0));

  // R12
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_hit != '0) |=> ((rise_lat & $past(rise_hit)) == $past(rise_hit)));
endmodule

bind evt_irq_ctrl evt_irq_chk #(.N(NUM_SRC_P), .AW(ADDR_W_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mask_q(mask_q), .wake_q(wake_q),
  .rise_hit(rise_hit), .rise_lat(rise_lat),
  .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  import evt_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_in;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;
  logic [5:0]  rd_addr;
  logic [31:0] rd_data;
  logic        req0_o, req1_o, wake_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] sh [NUM_CTL];
  logic [31:0] lat_r, lat_f, inp;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [2:0] code_of(input int i);
    return {sh[IDX_TRIG2][i], sh[IDX_TRIG1][i], sh[IDX_TRIG0][i]};
  endfunction

  function automatic logic [31:0] exp_cond(input logic [31:0] lvl);
    logic [31:0] c = '0;
    for (int i = 0; i < 32; i++) begin
      case (code_of(i))
        3'b001:  c[i] = lat_r[i];
        3'b010:  c[i] = lat_f[i];
        3'b011:  c[i] = lat_r[i] | lat_f[i];
        3'b101:  c[i] = lvl[i];
        3'b110:  c[i] = ~lvl[i];
        default: c[i] = 1'b0;
      endcase
    end
    return c & sh[IDX_SRCSEL];
  endfunction

  function automatic logic [31:0] rise_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = (code_of(i) == 3'b001) || (code_of(i) == 3'b011);
    return m;
  endfunction

  function automatic logic [31:0] fall_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = (code_of(i) == 3'b010) || (code_of(i) == 3'b011);
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; src_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < NUM_CTL; r++) begin
      rd(ctl_addr(r, K_RD), v);
      chk("R1 control reset", v, (r == IDX_SRCSEL || r == IDX_ROUTE) ? 32'hffff_ffff : 32'h0);
    end
    rd(A_RISE_RD, v); chk("R1 rise reg reset", v, 0);
    rd(A_FALL_RD, v); chk("R1 fall reg reset", v, 0);
    rd(A_TEST, v);    chk("R1 test reset", v, 0);
    chk("R1 outputs reset", {29'b0, req0_o, req1_o, wake_o}, 0);

    // R2 set/clear semantics, R14 test bit
    wr(ctl_addr(IDX_MASK, K_SET), 32'h0000_00f0);
    wr(ctl_addr(IDX_MASK, K_SET), 32'h0000_0003);
    rd(ctl_addr(IDX_MASK, K_RD), v); chk("R2 mask set", v, 32'h0000_00f3);
    wr(ctl_addr(IDX_MASK, K_CLR), 32'h0000_0011);
    rd(ctl_addr(IDX_MASK, K_RD), v); chk("R2 mask clear", v, 32'h0000_00e2);
    wr(ctl_addr(IDX_MASK, K_CLR), 32'hffff_ffff);
    wr(A_TEST, 32'h1); rd(A_TEST, v); chk("R14 test bit write 1", v, 1);
    wr(A_TEST, 32'h0); rd(A_TEST, v); chk("R14 test bit write 0", v, 0);

    // R3 R13 rising edge on source 0, routed to req0
    wr(ctl_addr(IDX_TRIG0, K_SET), 32'h1);
    wr(ctl_addr(IDX_MASK, K_SET), 32'h1);
    src_in[0] = 1'b1;                   // changes before edge k
    repeat (3) @(negedge clk);          // past k, k+1, k+2
    rd(A_PEND0, v); chk("R13 edge status after k+2", v, 32'h1);
    chk("R13 edge request not yet", {31'b0, req0_o}, 0);
    @(negedge clk);
    chk("R13 edge request after k+3", {31'b0, req0_o}, 1);
    src_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 rising stays captured after fall", {31'b0, req0_o}, 1);
    rd(A_FALL_RD, v); chk("R3 no falling capture in rise mode", v, 0);
    wr(A_RISE_CLR, 32'h1);
    rd(A_RISE_RD, v); chk("R3 rise clear", v, 0);
    @(negedge clk);
    chk("R3 request drops after clear", {31'b0, req0_o}, 0);

    // R6 R13 high level on source 1, routed to req1
    wr(ctl_addr(IDX_TRIG0, K_SET), 32'h2);
    wr(ctl_addr(IDX_TRIG2, K_SET), 32'h2);
    wr(ctl_addr(IDX_ROUTE, K_CLR), 32'h2);
    wr(ctl_addr(IDX_MASK, K_SET), 32'h2);
    src_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_PEND1, v); chk("R13 level status after k+1", v, 32'h2);
    chk("R13 level request not yet", {31'b0, req1_o}, 0);
    @(negedge clk);
    chk("R13 level request after k+2", {31'b0, req1_o}, 1);
    src_in[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 level not held", {31'b0, req1_o}, 0);

    // R12 edge and clear on the same clock edge, source 3
    wr(ctl_addr(IDX_TRIG0, K_SET), 32'h8);
    wr(ctl_addr(IDX_MASK, K_SET), 32'h8);
    src_in[3] = 1'b1; repeat (4) @(negedge clk);
    src_in[3] = 1'b0; repeat (4) @(negedge clk);
    rd(A_RISE_RD, v); chk("R12 first capture", v, 32'h8);
    src_in[3] = 1'b1;
    repeat (2) @(negedge clk);          // past k, k+1
    wr_en = 1'b1; wr_addr = A_RISE_CLR; wr_data = 32'h8;
    @(negedge clk);                     // past k+2: edge and clear together
    wr_en = 1'b0;
    rd(A_RISE_RD, v); chk("R12 edge wins over clear", v, 32'h8);
    @(negedge clk);
    chk("R12 request kept", {31'b0, req0_o}, 1);
    wr(A_RISE_CLR, 32'h8);
    rd(A_RISE_RD, v); chk("R12 plain clear", v, 0);

    // random rounds: R4 R5 R7 R8 R9 R10 R11
    wr(A_RISE_CLR, '1); wr(A_FALL_CLR, '1);
    lat_r = '0; lat_f = '0; inp = src_in;
    for (int it = 0; it < 80; it++) begin
      logic [31:0] nv, c, cr, cf;
      for (int r = 0; r < NUM_CTL; r++) begin
        v = $urandom;
        if (r == IDX_MASK || r == IDX_SRCSEL) v = v | $urandom;
        wr(ctl_addr(r, K_CLR), '1);
        wr(ctl_addr(r, K_SET), v);
        sh[r] = v;
      end
      nv = $urandom;
      src_in = nv;
      repeat (4) @(negedge clk);
      lat_r = lat_r | (~inp & nv & sh[IDX_SRCSEL] & rise_mask());
      lat_f = lat_f | (inp & ~nv & sh[IDX_SRCSEL] & fall_mask());
      inp = nv;
      c = exp_cond(inp);
      rd(A_RISE_RD, v); chk("R3 R5 R10 rising captures", v, lat_r);
      rd(A_FALL_RD, v); chk("R4 R5 R7 falling captures", v, lat_f);
      rd(A_PEND0, v);   chk("R8 R9 pending word 0", v, c & sh[IDX_MASK] & sh[IDX_ROUTE]);
      rd(A_PEND1, v);   chk("R8 R9 pending word 1", v, c & sh[IDX_MASK] & ~sh[IDX_ROUTE]);
      chk("R9 req0", {31'b0, req0_o}, {31'b0, |(c & sh[IDX_MASK] & sh[IDX_ROUTE])});
      chk("R9 req1", {31'b0, req1_o}, {31'b0, |(c & sh[IDX_MASK] & ~sh[IDX_ROUTE])});
      chk("R11 wake", {31'b0, wake_o}, {31'b0, |(c & sh[IDX_WAKE])});
      cr = $urandom; cf = $urandom;
      wr(A_RISE_CLR, cr); lat_r = lat_r & ~cr;
      wr(A_FALL_CLR, cf); lat_f = lat_f & ~cf;
      rd(A_RISE_RD, v); chk("R3 random rise clear", v, lat_r);
      rd(A_FALL_RD, v); chk("R4 random fall clear", v, lat_f);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule